// File: doc/BRIEF.md
# Part number string decoder

This block reads a board part-number record out of a word-addressed non-volatile store. It turns the record into a stream of ASCII bytes that ends in a NUL. A single `start` pulse latches the caller's buffer size limit. The block then reads two header words from fixed addresses. It decides between two record layouts and reports the outcome as a status code on a one-cycle `done` pulse. The status code is held until the next start. In the same cycle `out_len` gives the number of bytes in the finished string, counting the NUL.

When the first header word differs from a guard value, the record is in packed-hex form. The two header words then become an eleven-character `XXXXXX-0XX` string. When the first header word equals the guard value, the second header word is a pointer to a length-prefixed string of 16-bit words. Each word in that string gives two characters, high byte first. The block rejects bad lengths and buffers that are too small before it emits any byte.

Store reads use a request channel with valid/ready. The request address is held until the store accepts it. At most one read is outstanding at any time. The response is a single-cycle `rd_rsp_valid` strobe with data and an error flag, and the block always accepts it. The character stream uses valid/ready. A byte is transferred on each cycle where both are high. While `out_ready` is low, `out_data` and `out_last` stay frozen. The stream never advances without the ready signal.

Top module: `pn_decoder`

## Requirements
- R1: After start, the block reads address HDR0_ADDR (default 8) and then HDR1_ADDR (default 9). Each request holds `rd_req_valid` and `rd_addr` steady until `rd_req_ready`.
- R2: If the first header word w0 is not GUARD (default 0xFAFA), the stream is 11 bytes long and `out_len` is 11. The bytes are: w0 nibbles [15:12], [11:8], [7:4], [3:0]; then w1 [15:12], [11:8]; then '-' (0x2D); then '0'; then w1 [7:4], [3:0]; then NUL with `out_last` set.
- R3: In packed-hex mode, nibble values 0..9 become 0x30..0x39 and values 10..15 become 0x41..0x46.
- R4: In packed-hex mode, a size limit below 11 ends the run with status NOSPACE (1) and emits no byte.
- R5: In pointer mode, the word at address w1 is a length L in words that includes itself. L = 0 or L = 0xFFFF ends the run with status INVALID (2) and emits no byte.
- R6: In pointer mode, the required size is 2*L-1. A limit smaller than that ends the run with status NOSPACE and emits no byte. A limit exactly equal to it is accepted.
- R7: In pointer mode, the block reads words w1+1 .. w1+L-1 in order. It emits each word's high byte and then its low byte, followed by a NUL with `out_last` set. `out_len` equals 2*L-1 and status is OK (0).
- R8: A response with `rd_rsp_err` set ends the run at once with status RDERR (3). No further byte or NUL is emitted.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady. `out_last` is high only on the NUL byte.
- R10: A `start` pulse while `busy` is high is ignored. It changes neither the running decode nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode when idle |
| size_limit | input | 16 | Caller buffer size in bytes, latched at start |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 OK, 1 NOSPACE, 2 INVALID, 3 RDERR |
| out_len | output | 17 | String length including NUL |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Store accepts the request |
| rd_addr | output | AW | Word address of the read |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | 16 | Read data word |
| rd_rsp_err | input | 1 | Read failed |
| out_valid | output | 1 | Character byte valid |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Character byte |
| out_last | output | 1 | Marks the terminating NUL |

## Verification
The assertions rely on a few input rules. `rd_rsp_valid` may pulse only once for each accepted request, and never before that acceptance. `start` may be asserted at any time. The bench store model follows these rules: it answers each accepted request exactly once, after a delay of 0 to 2 cycles, and it changes its ready signals only between clock edges. The stimulus covers the legacy and pointer layouts, size limits just at and just below the boundary, both invalid length codes, read faults in both the header and the body, heavy output back-pressure, and a second start issued during a long run.

// File: rtl/pn_pkg.sv
package pn_pkg;
  typedef enum logic [1:0] {
    PN_OK      = 2'd0,
    PN_NOSPACE = 2'd1,
    PN_INVALID = 2'd2,
    PN_RDERR   = 2'd3
  } pn_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_LEG, S_HI, S_LO, S_NUL
  } pn_state_e;

  typedef enum logic [1:0] {
    PH_H0, PH_H1, PH_LEN, PH_BODY
  } pn_phase_e;

  localparam logic [7:0] PN_DASH = 8'h2D;
endpackage

// File: rtl/pn_hex_char.sv
module pn_hex_char (
  input  logic [3:0] nib,
  output logic [7:0] ch
);
  always_comb begin
    if (nib < 4'd10) ch = 8'h30 + {4'h0, nib};
    else             ch = 8'h37 + {4'h0, nib};
  end
endmodule

// File: rtl/pn_legacy_byte.sv
module pn_legacy_byte (
  input  logic [15:0] w0,
  input  logic [15:0] w1,
  input  logic [3:0]  idx,
  output logic [7:0]  ch,
  output logic        last
);
  import pn_pkg::*;
  localparam int NPOS = 16;

  logic [3:0] nib [NPOS];
  logic [7:0] asc [NPOS];

  always_comb begin
    for (int k = 0; k < NPOS; k++) nib[k] = 4'h0;
    nib[0] = w0[15:12];
    nib[1] = w0[11:8];
    nib[2] = w0[7:4];
    nib[3] = w0[3:0];
    nib[4] = w1[15:12];
    nib[5] = w1[11:8];
    nib[8] = w1[7:4];
    nib[9] = w1[3:0];
  end

  for (genvar k = 0; k < NPOS; k++) begin : g_hex
    pn_hex_char u_hex (.nib(nib[k]), .ch(asc[k]));
  end

  always_comb begin
    last = 1'b0;
    if (idx == 4'd6)       ch = PN_DASH;
    else if (idx == 4'd10) begin
      ch   = 8'h00;
      last = 1'b1;
    end
    else                   ch = asc[idx];
  end
endmodule

// File: rtl/pn_decoder.sv
module pn_decoder #(
  parameter int          AW        = 16,
  parameter int          HDR0_ADDR = 8,
  parameter int          HDR1_ADDR = 9,
  parameter logic [15:0] GUARD     = 16'hFAFA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   size_limit,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic [16:0]   out_len,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rsp_valid,
  input  logic [15:0]   rd_rsp_data,
  input  logic          rd_rsp_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);
  import pn_pkg::*;

  localparam int          LW       = 17;
  localparam logic [3:0]  LEG_LAST = 4'd10;
  localparam logic [LW-1:0] LEG_LEN = LW'(LEG_LAST) + LW'(1);

  pn_state_e  state_q;
  pn_phase_e  phase_q;
  pn_status_e status_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   w0_q, w1_q, cur_q, remain_q, limit_q;
  logic [3:0]    leg_idx_q;
  logic [LW-1:0] len_q;
  logic          done_q;

  logic [7:0]    leg_ch;
  logic          leg_last;
  logic [LW-1:0] need;

  assign need = {rd_rsp_data, 1'b0} - LW'(1);

  pn_legacy_byte u_leg (
    .w0(w0_q), .w1(w1_q), .idx(leg_idx_q), .ch(leg_ch), .last(leg_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      phase_q   <= PH_H0;
      status_q  <= PN_OK;
      addr_q    <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      cur_q     <= '0;
      remain_q  <= '0;
      limit_q   <= '0;
      leg_idx_q <= '0;
      len_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          limit_q  <= size_limit;
          addr_q   <= AW'(HDR0_ADDR);
          phase_q  <= PH_H0;
          status_q <= PN_OK;
          len_q    <= '0;
          state_q  <= S_REQ;
        end
        S_REQ: if (rd_req_ready) state_q <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            status_q <= PN_RDERR;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end else begin
            unique case (phase_q)
              PH_H0: begin
                w0_q    <= rd_rsp_data;
                addr_q  <= AW'(HDR1_ADDR);
                phase_q <= PH_H1;
                state_q <= S_REQ;
              end
              PH_H1: begin
                w1_q <= rd_rsp_data;
                if (w0_q != GUARD) begin
                  if ({1'b0, limit_q} < LEG_LEN) begin
                    status_q <= PN_NOSPACE;
                    done_q   <= 1'b1;
                    state_q  <= S_IDLE;
                  end else begin
                    len_q     <= LEG_LEN;
                    leg_idx_q <= '0;
                    state_q   <= S_LEG;
                  end
                end else begin
                  addr_q  <= rd_rsp_data[AW-1:0];
                  phase_q <= PH_LEN;
                  state_q <= S_REQ;
                end
              end
              PH_LEN: begin
                if (rd_rsp_data == 16'h0000 || rd_rsp_data == 16'hFFFF) begin
                  status_q <= PN_INVALID;
                  done_q   <= 1'b1;
                  state_q  <= S_IDLE;
                end else if ({1'b0, limit_q} < need) begin
                  status_q <= PN_NOSPACE;
                  done_q   <= 1'b1;
                  state_q  <= S_IDLE;
                end else begin
                  len_q    <= need;
                  remain_q <= rd_rsp_data - 16'd1;
                  addr_q   <= addr_q + AW'(1);
                  phase_q  <= PH_BODY;
                  state_q  <= (rd_rsp_data == 16'd1) ? S_NUL : S_REQ;
                end
              end
              default: begin
                cur_q   <= rd_rsp_data;
                state_q <= S_HI;
              end
            endcase
          end
        end
        S_LEG: if (out_ready) begin
          if (leg_idx_q == LEG_LAST) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            leg_idx_q <= leg_idx_q + 4'd1;
          end
        end
        S_HI: if (out_ready) state_q <= S_LO;
        S_LO: if (out_ready) begin
          remain_q <= remain_q - 16'd1;
          addr_q   <= addr_q + AW'(1);
          state_q  <= (remain_q == 16'd1) ? S_NUL : S_REQ;
        end
        S_NUL: if (out_ready) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    out_data = 8'h00;
    out_last = 1'b0;
    unique case (state_q)
      S_LEG: begin
        out_data = leg_ch;
        out_last = leg_last;
      end
      S_HI:  out_data = cur_q[15:8];
      S_LO:  out_data = cur_q[7:0];
      S_NUL: out_last = 1'b1;
      default: ;
    endcase
  end

  assign busy         = (state_q != S_IDLE);
  assign done         = done_q;
  assign status       = status_q;
  assign out_len      = len_q;
  assign rd_req_valid = (state_q == S_REQ);
  assign rd_addr      = addr_q;
  assign out_valid    = (state_q == S_LEG) || (state_q == S_HI) ||
                        (state_q == S_LO)  || (state_q == S_NUL);
endmodule

// File: rtl/pn_decoder_chk.sv
module pn_decoder_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [1:0]    status,
  input logic [16:0]   out_len,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last
);
  import pn_pkg::*;

  logic [16:0] sent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sent_q <= '0;
    else if (start && !busy) sent_q <= '0;
    else if (out_valid && out_ready) sent_q <= sent_q + 17'd1;
  end

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

  p_one_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && out_valid));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_nul_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_data == 8'h00);

  p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == PN_NOSPACE || status == PN_INVALID) |-> sent_q == 17'd0);

  p_ok_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == PN_OK |-> sent_q == out_len);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == PN_RDERR |-> !out_valid);
endmodule

bind pn_decoder pn_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .out_len(out_len), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/tb_pn_decoder.sv
`timescale 1ns/1ps
module tb_pn_decoder;
  localparam int          AW    = 16;
  localparam int          H0    = 8;
  localparam int          H1    = 9;
  localparam logic [15:0] GUARD = 16'hFAFA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] size_limit = '0;
  logic busy, done, rd_req_valid, out_valid, out_last;
  logic [1:0] status;
  logic [16:0] out_len;
  logic [AW-1:0] rd_addr;
  logic [7:0] out_data;
  logic rd_req_ready = 1'b0;
  logic rd_rsp_valid = 1'b0;
  logic [15:0] rd_rsp_data = '0;
  logic rd_rsp_err = 1'b0;
  logic out_ready = 1'b0;

  always #2.5 clk = ~clk;

  pn_decoder #(.AW(AW), .HDR0_ADDR(H0), .HDR1_ADDR(H1), .GUARD(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_limit(size_limit),
    .busy(busy), .done(done), .status(status), .out_len(out_len),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  logic [15:0] mem  [256];
  bit          errf [256];
  int exp_a[$];
  int exp_b[$];
  bit exp_l[$];
  int exp_st, exp_len;
  string cur_req;
  int total = 0, bad = 0, cyc = 0;
  bit bp_heavy = 0, done_seen = 0;
  int done_st = 0, done_len = 0;
  bit pend = 0;
  int pend_cnt = 0, pend_a = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int hexc(input int v);
    return (v < 10) ? (8'h30 + v) : (8'h41 + v - 10);
  endfunction

  // behavioural reference: expected reads, bytes, status and length
  task automatic build_expect(input int limit);
    int w0, w1, p, len, need;
    exp_a.delete(); exp_b.delete(); exp_l.delete();
    exp_len = -1;
    exp_a.push_back(H0);
    if (errf[H0]) begin exp_st = 3; return; end
    w0 = mem[H0];
    exp_a.push_back(H1);
    if (errf[H1]) begin exp_st = 3; return; end
    w1 = mem[H1];
    if (w0 != GUARD) begin
      int nb[10];
      if (limit < 11) begin exp_st = 1; return; end
      nb[0] = (w0 >> 12) & 15; nb[1] = (w0 >> 8) & 15;
      nb[2] = (w0 >> 4) & 15;  nb[3] = w0 & 15;
      nb[4] = (w1 >> 12) & 15; nb[5] = (w1 >> 8) & 15;
      nb[6] = 0;               nb[7] = 0;
      nb[8] = (w1 >> 4) & 15;  nb[9] = w1 & 15;
      for (int i = 0; i < 10; i++) begin
        exp_b.push_back(i == 6 ? 8'h2D : hexc(nb[i]));
        exp_l.push_back(1'b0);
      end
      exp_b.push_back(0); exp_l.push_back(1'b1);
      exp_st = 0; exp_len = 11;
      return;
    end
    p = w1 & 255;
    exp_a.push_back(p);
    if (errf[p]) begin exp_st = 3; return; end
    len = mem[p];
    if (len == 0 || len == 16'hFFFF) begin exp_st = 2; return; end
    need = 2 * len - 1;
    if (limit < need) begin exp_st = 1; return; end
    for (int i = 1; i < len; i++) begin
      int a;
      a = (p + i) & 255;
      exp_a.push_back(a);
      if (errf[a]) begin exp_st = 3; return; end
      exp_b.push_back(mem[a] >> 8);   exp_l.push_back(1'b0);
      exp_b.push_back(mem[a] & 255);  exp_l.push_back(1'b0);
    end
    exp_b.push_back(0); exp_l.push_back(1'b1);
    exp_st = 0; exp_len = need;
  endtask

  // store model, ready patterns and per-clock stream comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rd_rsp_valid = 1'b0;
      rd_rsp_err   = 1'b0;
      if (pend) begin
        if (pend_cnt == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mem[pend_a];
          rd_rsp_err   = errf[pend_a];
          pend = 0;
        end else pend_cnt--;
      end
      rd_req_ready = (cyc % 3) != 1;
      out_ready    = bp_heavy ? ((cyc % 4) == 0) : ((cyc % 5) != 2);
      #1;
      if (rst_n && rd_req_valid && rd_req_ready) begin
        int e;
        e = (exp_a.size() > 0) ? exp_a.pop_front() : -1;
        chk(int'(rd_addr) == e, "R1", "read address", int'(rd_addr), e);
        pend = 1; pend_cnt = cyc % 3; pend_a = int'(rd_addr) & 255;
      end
      if (rst_n && out_valid && out_ready) begin
        int eb; bit el;
        eb = (exp_b.size() > 0) ? exp_b.pop_front() : -1;
        el = (exp_l.size() > 0) ? exp_l.pop_front() : 1'b0;
        chk(int'(out_data) == eb, cur_req, "byte", int'(out_data), eb);
        chk(out_last == el, "R9", "last flag", int'(out_last), int'(el));
      end
      if (rst_n && done) begin
        done_seen = 1; done_st = int'(status); done_len = int'(out_len);
      end
    end
  end

  task automatic run_case(input int limit, input string req, input bit extra_start);
    int t;
    build_expect(limit);
    cur_req = req;
    done_seen = 0;
    @(negedge clk); #2;
    start = 1'b1; size_limit = 16'(limit);
    @(negedge clk); #2;
    start = 1'b0;
    if (extra_start) begin
      repeat (6) @(negedge clk);
      #2;
      chk(busy == 1'b1, "R10", "busy mid-run", int'(busy), 1);
      start = 1'b1; size_limit = 16'd0;
      @(negedge clk); #2;
      start = 1'b0;
    end
    t = 0;
    while (!done_seen && t < 4000) begin @(negedge clk); t++; end
    chk(done_seen, req, "watchdog done", int'(done_seen), 1);
    chk(done_st == exp_st, req, "status", done_st, exp_st);
    if (exp_st == 0) chk(done_len == exp_len, "R7", "out_len", done_len, exp_len);
    chk(exp_b.size() == 0, req, "bytes missing", exp_b.size(), 0);
    chk(exp_a.size() == 0, "R1", "reads missing", exp_a.size(), 0);
    repeat (8) @(negedge clk);
    #2;
    chk(busy == 1'b0 && out_valid == 1'b0, "R10", "idle after run", int'(busy), 0);
  endtask

  task automatic set_ptr(input int p, input int len);
    mem[H0] = GUARD; mem[H1] = 16'(p); mem[p] = 16'(len);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'(i * 16'h0101); errf[i] = 0; end
    repeat (4) @(negedge clk);
    #2;
    chk(busy == 0 && out_valid == 0 && rd_req_valid == 0 && done == 0,
        "R1", "reset state", int'({busy, out_valid, rd_req_valid, done}), 0);
    rst_n = 1'b1;

    // R2 R3: packed hex with digits and letters
    mem[H0] = 16'h1A3F; mem[H1] = 16'hC5E9;
    run_case(11, "R2", 0);
    mem[H0] = 16'h0123; mem[H1] = 16'h4567;
    run_case(40, "R3", 0);
    bp_heavy = 1;
    mem[H0] = 16'h89AB; mem[H1] = 16'hCDEF;
    run_case(11, "R3", 0);
    bp_heavy = 0;
    // R4: limit one short
    run_case(10, "R4", 0);

    // R7 R6: pointer at exact limit
    set_ptr(32, 4);
    mem[33] = 16'h4142; mem[34] = 16'h4344; mem[35] = 16'h0045;
    run_case(7, "R7", 0);
    run_case(6, "R6", 0);
    // R10: second start mid-run, with back-pressure
    bp_heavy = 1;
    run_case(7, "R10", 1);
    bp_heavy = 0;
    // R5: invalid lengths
    set_ptr(48, 0);
    run_case(100, "R5", 0);
    set_ptr(48, 16'hFFFF);
    run_case(100, "R5", 0);
    // R7: length one gives NUL only
    set_ptr(64, 1);
    run_case(1, "R7", 0);
    // R8: read fault in body and in header
    set_ptr(32, 4);
    errf[34] = 1;
    run_case(50, "R8", 0);
    errf[34] = 0;
    errf[H0] = 1;
    run_case(50, "R8", 0);
    errf[H0] = 0;
    // recovery after fault
    run_case(7, "R7", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule